// File: doc/BRIEF.md
# Trigger-Gated Compare-Match Timer

An 8-bit up-counter with two compare channels and a small synchronous register port. The counter advances on ticks from an internal prescaler whose rate is set by a 4-bit clock code. The code is split across two registers: a 3-bit field in the configuration register and one bit in the trigger control register. Each compare channel drives its own output pin. When the counter equals that channel's compare value on a counting tick, the pin is held, driven low, driven high or toggled, according to the channel's own 2-bit level operation.

The counter can be gated by an external trigger pin. The pin is synchronized and then edge-detected against a selectable edge set. With gating enabled, counting begins only after an accepted edge. A compare match that clears the counter also stops it, so each trigger yields exactly one counting run. With gating disabled, the pin is ignored and the counter runs freely.

Top module: `cmt_timer`

## Requirements
- R1: After reset both outputs are 0, the counter, compare and configuration fields are 0, and the trigger control register reads 0xE2.
- R2: Registers sit at address 0 (configuration: clear mode bits 4:3, clock code low bits 2:0), 1 (trigger control), 2 (level operations: channel A bits 1:0, channel B bits 3:2), 3 (counter), 4 (compare A) and 5 (compare B). A read returns data on rdata one clock after the address is presented. In the trigger control register, bits 7:5 and bit 1 always read 1.
- R3: The clock code is {trigger control bit 0, configuration bits 2:0}. Codes 1 to 6 advance the counter once every 2^(code+1) clocks, which gives 4 to 128. Code 0 and codes 7 to 15 stop the counter.
- R4: A match on a channel occurs on a counting tick while the counter equals that channel's compare value. Clear mode 00 never clears, 01 clears on A, 10 clears on B and 11 clears on either. A clearing match loads 0 in place of the increment. Otherwise the counter wraps from 255 to 0.
- R5: On its own match, each output applies its level operation: 00 hold, 01 drive 0, 10 drive 1, 11 toggle. A and B matching in the same tick update independently. An output changes at no other time.
- R6: Trigger control bits 4:3 select the accepted edges of trig_in (00 none, 01 rising, 10 falling, 11 both). trig_in passes through two synchronizing flops. With trigger control bit 2 set, the counter stays still until an accepted edge arrives.
- R7: With gating enabled, a clearing match stops the counter at 0 until the next accepted edge. Any write to the trigger control register also returns the counter to waiting.
- R8: With gating disabled, trig_in has no effect and the counter runs at the selected rate.
- R9: A write to the counter register takes priority over a counting tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| trig_in | input | 1 | External trigger pin |
| out_a | output | 1 | Channel A timer output |
| out_b | output | 1 | Channel B timer output |

## Verification
Most internal faults appear within a few prescaler periods on out_a or out_b. A wrong prescaler divisor changes the spacing between toggles, so the bench measures that spacing for every clock code. A run flag stuck high or low shows up as a counter value that is nonzero or zero when read back after a trigger edge, or as a second toggle in a run that should have halted. Errors in the level operations appear on the very next match, and the bench checks all sixteen pairs of A and B operations against a state model.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    localparam int CNT_W   = 8;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int NCH     = 2;
    localparam int CODE_W  = 4;
    localparam int PSC_W   = 7;

    localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
    localparam logic [ADDR_W-1:0] A_TRG  = 3'd1;
    localparam logic [ADDR_W-1:0] A_LVL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CMP0 = 3'd4;

    typedef enum logic [1:0] {
        LVL_HOLD = 2'b00,
        LVL_LOW  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_FLIP = 2'b11
    } lvl_op_e;

    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        logic [NCH-1:0][CNT_W-1:0]   cmp;
        logic [NCH-1:0][1:0]         op;
        logic [1:0]                  clr_mode;
        logic [2:0]                  cks_lo;
        logic                        cks_hi;
        logic [1:0]                  edge_sel;
        logic                        gate_en;
        logic [DATA_W-1:0]           rdata;
    } tmr_state_t;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
#(
    parameter int W      = PSC_W,
    parameter int CODE_B = CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_B-1:0] code_i,
    output logic              tick_o
);
    logic [W-1:0] psc_d, psc_q;
    logic [W-1:0] mask;
    logic         valid;

    always_comb begin
        psc_d = psc_q + 1'b1;
        valid = (code_i != '0) && (int'(code_i) < W);
        for (int i = 0; i < W; i++) begin
            mask[i] = (i <= int'(code_i));
        end
        tick_o = valid && ((psc_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
    end

    // R3: the fastest rate is one tick in four clocks
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/cmt_trigger.sv
module cmt_trigger (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_i,
    input  logic [1:0] edge_sel_i,
    input  logic       gate_en_i,
    input  logic       restart_i,
    input  logic       halt_i,
    output logic       run_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic run;
    } trg_state_t;

    trg_state_t st_d, st_q;
    logic rise, fall, accept;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = trig_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        rise   = st_q.s2 && !st_q.prev;
        fall   = !st_q.s2 && st_q.prev;
        accept = (edge_sel_i[0] && rise) || (edge_sel_i[1] && fall);
        if (restart_i || halt_i)      st_d.run = 1'b0;
        else if (accept && gate_en_i) st_d.run = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o = st_q.run;

    // R6: a run starts only from an accepted edge while gating is on
    assert_run_from_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.run) |-> $past(gate_en_i && !restart_i && !halt_i));
endmodule

// File: rtl/cmt_outlvl.sv
module cmt_outlvl
    import cmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_i,
    input  logic [1:0] op_i,
    output logic       lvl_o
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (hit_i) begin
            unique case (lvl_op_e'(op_i))
                LVL_HOLD: lvl_d = lvl_q;
                LVL_LOW:  lvl_d = 1'b0;
                LVL_HIGH: lvl_d = 1'b1;
                LVL_FLIP: lvl_d = !lvl_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    assign lvl_o = lvl_q;

    // R5: the output moves only after its own match
    assert_lvl_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_q) |-> $past(hit_i));
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              trig_in,
    output logic              out_a,
    output logic              out_b
);
    tmr_state_t          st_d, st_q;
    logic                tick, run, cnt_en, clr_hit, halt, trg_wr, cnt_wr;
    logic [NCH-1:0]      hit;
    logic [NCH-1:0]      lvl;
    logic [CODE_W-1:0]   code;

    assign code   = {st_q.cks_hi, st_q.cks_lo};
    assign trg_wr = wr_en && (addr == A_TRG);
    assign cnt_wr = wr_en && (addr == A_CNT);

    cmt_prescaler u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .code_i (code),
        .tick_o (tick)
    );

    cmt_trigger u_trg (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig_in),
        .edge_sel_i (st_q.edge_sel),
        .gate_en_i  (st_q.gate_en),
        .restart_i  (trg_wr),
        .halt_i     (halt),
        .run_o      (run)
    );

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            cmt_outlvl u_lvl (
                .clk   (clk),
                .rst_n (rst_n),
                .hit_i (hit[ch]),
                .op_i  (st_q.op[ch]),
                .lvl_o (lvl[ch])
            );
        end
    endgenerate

    assign out_a = lvl[0];
    assign out_b = lvl[1];
    assign rdata = st_q.rdata;

    always_comb begin
        st_d   = st_q;
        cnt_en = tick && (!st_q.gate_en || run);
        for (int ch = 0; ch < NCH; ch++) begin
            hit[ch] = cnt_en && (st_q.cnt == st_q.cmp[ch]);
        end
        clr_hit = (st_q.clr_mode[0] && hit[0]) || (st_q.clr_mode[1] && hit[1]);
        halt    = clr_hit && st_q.gate_en;

        if (cnt_en) st_d.cnt = clr_hit ? '0 : st_q.cnt + 1'b1;

        if (wr_en) begin
            case (addr)
                A_CFG: begin
                    st_d.clr_mode = wdata[4:3];
                    st_d.cks_lo   = wdata[2:0];
                end
                A_TRG: begin
                    st_d.edge_sel = wdata[4:3];
                    st_d.gate_en  = wdata[2];
                    st_d.cks_hi   = wdata[0];
                end
                A_LVL: begin
                    st_d.op[0] = wdata[1:0];
                    st_d.op[1] = wdata[3:2];
                end
                A_CNT:      st_d.cnt    = wdata;
                A_CMP0:     st_d.cmp[0] = wdata;
                A_CMP0 + 1: st_d.cmp[1] = wdata;
                default: ;
            endcase
        end

        case (addr)
            A_CFG:      st_d.rdata = {3'b000, st_q.clr_mode, st_q.cks_lo};
            A_TRG:      st_d.rdata = {3'b111, st_q.edge_sel, st_q.gate_en, 1'b1, st_q.cks_hi};
            A_LVL:      st_d.rdata = {4'b0000, st_q.op[1], st_q.op[0]};
            A_CNT:      st_d.rdata = st_q.cnt;
            A_CMP0:     st_d.rdata = st_q.cmp[0];
            A_CMP0 + 1: st_d.rdata = st_q.cmp[1];
            default:    st_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: reserved trigger-control bits read back as ones
    assert_trg_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_TRG) |=> (rdata[7:5] == 3'b111 && rdata[1]));

    // R3: without a tick or a write the counter holds
    assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(st_q.cnt));

    // R7: a clearing match under gating ends the run
    assert_halt_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && st_q.gate_en) |=> !run);

    // R9: a counter write wins over a tick
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (st_q.cnt == $past(wdata)));
endmodule

// File: tb/cmt_timer_bench.sv
`timescale 1ns/1ps
module cmt_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       trig_in = 1'b0;
    logic       out_a, out_b;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = !clk;
    always @(posedge clk) cyc <= cyc + 1;

    cmt_timer u_cmt_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .trig_in(trig_in), .out_a(out_a), .out_b(out_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        @(negedge clk);
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic apply_op(input logic [1:0] op, input logic prev);
        case (op)
            2'b00:   return prev;
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            default: return !prev;
        endcase
    endfunction

    initial begin
        #(5.0 * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic ea, eb, o0;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        chk(out_a == 1'b0 && out_b == 1'b0, "R1 outputs", {out_b, out_a}, 0);
        rd(3'd1, d); chk(d == 8'hE2, "R1 trigger ctl", d, 8'hE2);
        rd(3'd0, d); chk(d == 8'h00, "R1 config", d, 0);
        rd(3'd3, d); chk(d == 8'h00, "R1 counter", d, 0);

        // R2: readback and reserved bits
        wr(3'd4, 8'hA5); rd(3'd4, d); chk(d == 8'hA5, "R2 cmp A", d, 8'hA5);
        wr(3'd5, 8'h3C); rd(3'd5, d); chk(d == 8'h3C, "R2 cmp B", d, 8'h3C);
        wr(3'd1, 8'h00); rd(3'd1, d); chk(d == 8'hE2, "R2 reserved ones", d, 8'hE2);
        wr(3'd1, 8'h1D); rd(3'd1, d); chk(d == 8'hFF, "R2 trigger ctl", d, 8'hFF);
        wr(3'd1, 8'h00);
        wr(3'd2, 8'h0B); rd(3'd2, d); chk(d == 8'h0B, "R2 level ops", d, 8'h0B);
        wr(3'd3, 8'h77); rd(3'd3, d); chk(d == 8'h77, "R2 counter", d, 8'h77);

        // R3, R4: every clock code, toggle period on out_a with cmpA=0 cleared on A
        for (int code = 0; code < 16; code++) begin
            int t0, gap;
            logic prev;
            wr(3'd2, 8'h03);
            wr(3'd4, 8'h00);
            wr(3'd0, {3'b000, 2'b01, code[2:0]});
            wr(3'd1, {3'b111, 2'b00, 1'b0, 1'b1, code[3]});
            wr(3'd3, 8'h00);
            t0 = -1; gap = 0; prev = out_a;
            for (int i = 0; i < 600; i++) begin
                @(negedge clk);
                if (out_a != prev) begin
                    prev = out_a;
                    if (t0 < 0) t0 = cyc;
                    else begin gap = cyc - t0; break; end
                end
            end
            if (code >= 1 && code <= 6)
                chk(gap == (1 << (code + 1)), $sformatf("R3 period code %0d", code), gap, 1 << (code + 1));
            else
                chk(t0 < 0, $sformatf("R3 stopped code %0d", code), t0, -1);
        end

        // R4: clear on B keeps counter at or below cmpB
        wr(3'd0, {3'b000, 2'b10, 3'b001});
        wr(3'd1, 8'h00);
        wr(3'd5, 8'h03);
        wr(3'd4, 8'h80);
        wr(3'd3, 8'h00);
        for (int k = 0; k < 6; k++) begin
            idle(7);
            rd(3'd3, d); chk(d <= 8'h03, "R4 clear on B", d, 3);
        end
        // R4: no clear mode wraps past 255
        wr(3'd0, {3'b000, 2'b00, 3'b001});
        wr(3'd3, 8'hFE);
        idle(14);
        rd(3'd3, d); chk(d >= 8'h01 && d <= 8'h04, "R4 wrap", d, 2);

        // R9: continuous writes win over ticks
        @(negedge clk); wr_en = 1'b1; addr = 3'd3; wdata = 8'h55;
        idle(12);
        chk(rdata == 8'h55, "R9 write priority", rdata, 8'h55);
        @(negedge clk); wr_en = 1'b0;

        // R5: all operation pairs, simultaneous matches, code 1, no clear
        wr(3'd0, {3'b000, 2'b00, 3'b001});
        wr(3'd4, 8'd9);
        wr(3'd5, 8'd9);
        ea = out_a; eb = out_b;
        for (int sa = 0; sa < 4; sa++)
            for (int sb = 0; sb < 4; sb++)
                for (int rep = 0; rep < 2; rep++) begin
                    wr(3'd2, {4'b0000, sb[1:0], sa[1:0]});
                    wr(3'd3, 8'd9);
                    idle(10);
                    ea = apply_op(sa[1:0], ea);
                    eb = apply_op(sb[1:0], eb);
                    chk(out_a == ea, $sformatf("R5 out_a op %0d", sa), out_a, ea);
                    chk(out_b == eb, $sformatf("R5 out_b op %0d", sb), out_b, eb);
                end

        // R6: edge select sweep under gating, code 1, no clear
        wr(3'd0, {3'b000, 2'b00, 3'b001});
        wr(3'd4, 8'hFF);
        wr(3'd5, 8'hFF);
        for (int m = 0; m < 4; m++)
            for (int dir = 0; dir < 2; dir++) begin
                logic started;
                trig_in = (dir == 1);
                idle(6);
                wr(3'd1, {3'b111, m[1:0], 1'b1, 1'b1, 1'b0});
                wr(3'd3, 8'h00);
                idle(20);
                rd(3'd3, d); chk(d == 8'h00, $sformatf("R6 waiting mode %0d", m), d, 0);
                trig_in = (dir == 0);
                idle(40);
                started = (dir == 0) ? m[0] : m[1];
                rd(3'd3, d);
                chk((d != 8'h00) == started, $sformatf("R6 mode %0d dir %0d", m, dir), d, started);
            end

        // R7: a clearing match halts the run; next edge gives exactly one more
        trig_in = 1'b0;
        idle(6);
        wr(3'd2, 8'h03);
        wr(3'd4, 8'h03);
        wr(3'd0, {3'b000, 2'b01, 3'b001});
        wr(3'd1, {3'b111, 2'b01, 1'b1, 1'b1, 1'b0});
        wr(3'd3, 8'h00);
        o0 = out_a;
        for (int run_i = 1; run_i <= 2; run_i++) begin
            trig_in = 1'b1;
            idle(100);
            rd(3'd3, d); chk(d == 8'h00, "R7 halted at zero", d, 0);
            chk(out_a == (o0 ^ run_i[0]), "R7 one toggle per run", out_a, o0 ^ run_i[0]);
            trig_in = 1'b0;
            idle(10);
        end
        // R7: control write returns to waiting
        trig_in = 1'b1;
        idle(8);
        wr(3'd4, 8'hFF);
        wr(3'd1, {3'b111, 2'b01, 1'b1, 1'b1, 1'b0});
        wr(3'd3, 8'h00);
        idle(30);
        rd(3'd3, d); chk(d == 8'h00, "R7 restart on write", d, 0);

        // R8: gating off, trigger ignored, counter runs
        wr(3'd1, {3'b111, 2'b11, 1'b0, 1'b1, 1'b0});
        wr(3'd3, 8'h00);
        for (int k = 0; k < 4; k++) begin
            trig_in = !trig_in;
            idle(9);
        end
        rd(3'd3, d); chk(d >= 8'd8 && d <= 8'd11, "R8 free running", d, 9);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule